// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block holds a small set of recently used page mappings and translates a virtual page number into a physical page number in the same cycle it is asked. Every slot carries a virtual page tag, a physical page number, separate per-privilege-mode read and write enable masks, two fault-on-access flags, a global flag and an address space identifier. A lookup succeeds only on a slot whose tag matches and which is either global or belongs to the address space being looked up. Because of that rule, the same virtual page may be held several times under different address spaces.

New mappings are written into the slot named by a rotating replacement pointer. Any mapping already held in that slot is overwritten. Three invalidation commands exist: clear the whole buffer, drop every non-global mapping (used on an address space switch), and drop the mappings of one virtual address under one address space. Page table walking, permission evaluation and fault reporting are left to the surrounding logic, which consumes the returned fields.

With the default sizes, a virtual address is 24 bits wide and a page is 256 bytes. The virtual page number is therefore address bits 23..8. Physical page numbers are 14 bits, address space identifiers are 8 bits, and there are four privilege modes.

Top module: `xlat_buf`

## Requirements
- R1: A slot hits only if it is valid, its tag equals `lk_vpn`, and either its global flag is set or its stored address space equals `lk_asn`. A tag match under a different address space on a non-global slot is a miss.
- R2: When several slots hit at once, the lowest-numbered hitting slot is reported on `lk_idx` together with its fields. A tag-only match that fails the address-space rule is never chosen.
- R3: An accepted insert writes the slot named by the replacement pointer and marks it valid. The tag is taken as bits 23..8 of `ins_va`; bits 7..0 are discarded. A later hit returns exactly the inserted physical page, read mask, write mask, fault flags and global flag.
- R4: The replacement pointer is 0 after reset. It advances by one on each accepted insert only, and returns to 0 after slot `ENTRIES-1`.
- R5: Inserting into a slot that already holds a valid mapping discards the old mapping; its virtual page no longer hits in that slot.
- R6: `flush_all` invalidates every slot, clears every field to zero and returns the replacement pointer to 0.
- R7: `flush_local` invalidates every non-global slot and leaves every global slot untouched.
- R8: `flush_one` invalidates only the slots that would hit for the page of `flush_va` (bits 23..8) under `flush_asn`, using the R1 rule, which includes global slots of that page. All other slots stay valid.
- R9: Only one command acts per cycle, in this priority order: `flush_all`, then `flush_local`, then `flush_one`, then `ins_valid`. A lower-priority command raised in the same cycle is dropped entirely, and a dropped insert does not move the pointer.
- R10: On a miss, `lk_hit`, `lk_idx` and all returned fields are zero. After reset no slot hits.
- R11: Lookup is combinational on the current table. A command accepted on a clock edge is visible to the lookup immediately after that edge; in the cycle the command is presented, the lookup still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vpn | input | 16 | Virtual page number to translate |
| lk_asn | input | 8 | Current address space identifier |
| lk_hit | output | 1 | A slot satisfied the hit rule |
| lk_idx | output | log2(ENTRIES) | Index of the reported slot |
| lk_ppn | output | 14 | Physical page number of the reported slot |
| lk_rd_en | output | 4 | Per-mode read enables of the reported slot |
| lk_wr_en | output | 4 | Per-mode write enables of the reported slot |
| lk_f_rd | output | 1 | Fault-on-read flag of the reported slot |
| lk_f_wr | output | 1 | Fault-on-write flag of the reported slot |
| lk_glob | output | 1 | Global flag of the reported slot |
| ins_valid | input | 1 | Insert request |
| ins_va | input | 24 | Virtual address of the new mapping |
| ins_ppn | input | 14 | Physical page number of the new mapping |
| ins_rd_en | input | 4 | Per-mode read enables of the new mapping |
| ins_wr_en | input | 4 | Per-mode write enables of the new mapping |
| ins_f_rd | input | 1 | Fault-on-read flag of the new mapping |
| ins_f_wr | input | 1 | Fault-on-write flag of the new mapping |
| ins_glob | input | 1 | Global flag of the new mapping |
| ins_asn | input | 8 | Address space identifier of the new mapping |
| flush_all | input | 1 | Invalidate all slots and reset the pointer |
| flush_local | input | 1 | Invalidate all non-global slots |
| flush_one | input | 1 | Invalidate slots hitting `flush_va` under `flush_asn` |
| flush_va | input | 24 | Virtual address for `flush_one` |
| flush_asn | input | 8 | Address space identifier for `flush_one` |

## Verification
A corrupted slot or a stuck valid bit appears at the ports as soon as that page is looked up, because the lookup is combinational; the error shows in the same cycle the page is presented. A wrong replacement pointer shows one cycle after the next insert, since `lk_idx` then reports an unexpected slot. It also surfaces later as a mapping that survives or vanishes out of turn once the pointer wraps. A command applied with the wrong priority or scope shows as a hit or miss that differs from the reference model on the very next lookup of an affected page, so the bench compares the full lookup result on every clock.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int VA_W    = 24;
    localparam int PG_BITS = 8;
    localparam int VPN_W   = VA_W - PG_BITS;
    localparam int PPN_W   = 14;
    localparam int ASN_W   = 8;
    localparam int NMODE   = 4;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  tag;
        logic [PPN_W-1:0]  ppn;
        logic [NMODE-1:0]  rd_en;
        logic [NMODE-1:0]  wr_en;
        logic              f_rd;
        logic              f_wr;
        logic              glob;
        logic [ASN_W-1:0]  asn;
    } pte_t;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_FLUSH_ALL,
        CMD_FLUSH_LOCAL,
        CMD_FLUSH_ONE,
        CMD_INSERT
    } cmd_e;

    function automatic logic [VPN_W-1:0] va_vpn(input logic [VA_W-1:0] va);
        return va[VA_W-1:PG_BITS];
    endfunction

    // slot selection rule: valid, tag equal, and global or same space
    function automatic logic pte_match(input pte_t e,
                                       input logic [VPN_W-1:0] vpn,
                                       input logic [ASN_W-1:0] asn);
        return e.valid && (e.tag == vpn) && (e.glob || (e.asn == asn));
    endfunction

    // one command per cycle, fixed priority
    function automatic cmd_e pick_cmd(input logic fa, input logic fl,
                                      input logic fo, input logic ins);
        if (fa)       return CMD_FLUSH_ALL;
        else if (fl)  return CMD_FLUSH_LOCAL;
        else if (fo)  return CMD_FLUSH_ONE;
        else if (ins) return CMD_INSERT;
        else          return CMD_IDLE;
    endfunction

endpackage

// File: rtl/xlat_match.sv
module xlat_match
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 48
) (
    input  pte_t              tbl [ENTRIES],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASN_W-1:0]  asn,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = pte_match(tbl[i], vpn, asn);
    end

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output logic [ENTRIES-1:0] grant
);

    // lowest index wins: scan from the top so the last write is the lowest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R2

    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        found |-> ((req & (grant - 1'b1)) == '0)); // R2

    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (rst)
        found |-> ((grant & req) != '0)); // R2

endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
    parameter int ENTRIES = 48,
    parameter int IDX_W   = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             advance,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clear |=> (ptr == '0)); // R6

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (advance && !clear) |=> ((ptr == '0) || (ptr == $past(ptr) + 1'b1))); // R4

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!advance && !clear) |=> $stable(ptr)); // R4

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST); // R4

endmodule

// File: rtl/xlat_buf.sv
module xlat_buf
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 48,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      lk_vpn,
    input  logic [7:0]       lk_asn,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [13:0]      lk_ppn,
    output logic [3:0]       lk_rd_en,
    output logic [3:0]       lk_wr_en,
    output logic             lk_f_rd,
    output logic             lk_f_wr,
    output logic             lk_glob,
    input  logic             ins_valid,
    input  logic [23:0]      ins_va,
    input  logic [13:0]      ins_ppn,
    input  logic [3:0]       ins_rd_en,
    input  logic [3:0]       ins_wr_en,
    input  logic             ins_f_rd,
    input  logic             ins_f_wr,
    input  logic             ins_glob,
    input  logic [7:0]       ins_asn,
    input  logic             flush_all,
    input  logic             flush_local,
    input  logic             flush_one,
    input  logic [23:0]      flush_va,
    input  logic [7:0]       flush_asn
);

    pte_t               tbl [ENTRIES];
    pte_t               new_pte;
    pte_t               sel_pte;
    cmd_e               cmd;
    logic [IDX_W-1:0]   ptr;
    logic [ENTRIES-1:0] lk_hits;
    logic [ENTRIES-1:0] lk_grant;
    logic [ENTRIES-1:0] fl_hits;
    logic [ENTRIES-1:0] valid_vec;
    logic [ENTRIES-1:0] glob_vec;

    assign cmd = pick_cmd(flush_all, flush_local, flush_one, ins_valid);

    always_comb begin
        new_pte       = '0;
        new_pte.valid = 1'b1;
        new_pte.tag   = va_vpn(ins_va);
        new_pte.ppn   = ins_ppn;
        new_pte.rd_en = ins_rd_en;
        new_pte.wr_en = ins_wr_en;
        new_pte.f_rd  = ins_f_rd;
        new_pte.f_wr  = ins_f_wr;
        new_pte.glob  = ins_glob;
        new_pte.asn   = ins_asn;
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_flags
        assign valid_vec[i] = tbl[i].valid;
        assign glob_vec[i]  = tbl[i].glob;
    end

    // lookup comparators
    xlat_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .tbl     (tbl),
        .vpn     (lk_vpn),
        .asn     (lk_asn),
        .hit_vec (lk_hits)
    );

    // single-address invalidate comparators
    xlat_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .tbl     (tbl),
        .vpn     (va_vpn(flush_va)),
        .asn     (flush_asn),
        .hit_vec (fl_hits)
    );

    xlat_pick #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_pick (
        .clk   (clk),
        .rst   (rst),
        .req   (lk_hits),
        .found (lk_hit),
        .idx   (lk_idx),
        .grant (lk_grant)
    );

    xlat_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst     (rst),
        .clear   (cmd == CMD_FLUSH_ALL),
        .advance (cmd == CMD_INSERT),
        .ptr     (ptr)
    );

    // one-hot AND-OR read mux; zero on a miss
    always_comb begin
        sel_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_grant[i]) sel_pte = sel_pte | tbl[i];
        end
    end

    assign lk_ppn   = sel_pte.ppn;
    assign lk_rd_en = sel_pte.rd_en;
    assign lk_wr_en = sel_pte.wr_en;
    assign lk_f_rd  = sel_pte.f_rd;
    assign lk_f_wr  = sel_pte.f_wr;
    assign lk_glob  = sel_pte.glob;

    // table storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else begin
            case (cmd)
                CMD_FLUSH_ALL: begin
                    for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
                end
                CMD_FLUSH_LOCAL: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (!tbl[i].glob) tbl[i].valid <= 1'b0;
                end
                CMD_FLUSH_ONE: begin
                    for (int i = 0; i < ENTRIES; i++)
                        if (fl_hits[i]) tbl[i].valid <= 1'b0;
                end
                CMD_INSERT: begin
                    tbl[ptr] <= new_pte;
                end
                default: ;
            endcase
        end
    end

    AST_HIT_RULE: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (tbl[lk_idx].valid && (tbl[lk_idx].tag == lk_vpn) &&
                    (tbl[lk_idx].glob || (tbl[lk_idx].asn == lk_asn)))); // R1

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> ((lk_idx == '0) && (lk_ppn == '0) && (lk_rd_en == '0) &&
                     (lk_wr_en == '0) && !lk_f_rd && !lk_f_wr && !lk_glob)); // R10

    AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_INSERT) |=> (tbl[$past(ptr)].valid &&
                                 (tbl[$past(ptr)].tag == $past(ins_va[23:8])))); // R3

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> ((valid_vec == '0) && !lk_hit)); // R6

    AST_LOCAL_GONE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FLUSH_LOCAL) |=> ((valid_vec & ~glob_vec) == '0)); // R7

    AST_LOCAL_KEEPS_GLOBAL: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FLUSH_LOCAL) |=> ((valid_vec & glob_vec) == $past(valid_vec & glob_vec))); // R7

    AST_ONE_GONE: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FLUSH_ONE) |=> ((valid_vec & $past(fl_hits)) == '0)); // R8

    AST_ONE_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_FLUSH_ONE) |=> ((valid_vec & ~$past(fl_hits)) == $past(valid_vec & ~fl_hits))); // R8

    AST_PRIO_LOCAL_OVER_INS: assert property (@(posedge clk) disable iff (rst)
        (flush_local && !flush_all && ins_valid) |=> ($countones(valid_vec) <= $past($countones(valid_vec)))); // R9

endmodule

// File: tb/xlat_buf_tb.sv
`timescale 1ns/1ps
module xlat_buf_tb;
    import xlat_pkg::*;

    localparam int N  = 48;
    localparam int IW = $clog2(N);
    localparam int OW = 1 + IW + PPN_W + 2 * NMODE + 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst;
    logic [15:0]       lk_vpn;
    logic [7:0]        lk_asn;
    logic              lk_hit;
    logic [IW-1:0]     lk_idx;
    logic [13:0]       lk_ppn;
    logic [3:0]        lk_rd_en, lk_wr_en;
    logic              lk_f_rd, lk_f_wr, lk_glob;
    logic              ins_valid;
    logic [23:0]       ins_va;
    logic [13:0]       ins_ppn;
    logic [3:0]        ins_rd_en, ins_wr_en;
    logic              ins_f_rd, ins_f_wr, ins_glob;
    logic [7:0]        ins_asn;
    logic              flush_all, flush_local, flush_one;
    logic [23:0]       flush_va;
    logic [7:0]        flush_asn;

    xlat_buf #(.ENTRIES(N)) u_dut (
        .clk(clk), .rst(rst),
        .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_f_rd(lk_f_rd), .lk_f_wr(lk_f_wr), .lk_glob(lk_glob),
        .ins_valid(ins_valid), .ins_va(ins_va), .ins_ppn(ins_ppn),
        .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en), .ins_f_rd(ins_f_rd),
        .ins_f_wr(ins_f_wr), .ins_glob(ins_glob), .ins_asn(ins_asn),
        .flush_all(flush_all), .flush_local(flush_local), .flush_one(flush_one),
        .flush_va(flush_va), .flush_asn(flush_asn)
    );

    // behavioural reference: plain arrays and a counter
    logic              m_v   [N];
    logic [15:0]       m_tag [N];
    logic [13:0]       m_ppn [N];
    logic [3:0]        m_rd  [N];
    logic [3:0]        m_wr  [N];
    logic              m_fr  [N];
    logic              m_fw  [N];
    logic              m_g   [N];
    logic [7:0]        m_asn [N];
    int                m_ptr;

    int    n_chk  = 0;
    int    n_fail = 0;
    string req    = "R10";
    bit    done   = 1'b0;

    task automatic model_clear();
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_ppn[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
            m_fr[i] = 0; m_fw[i] = 0; m_g[i] = 0; m_asn[i] = '0;
        end
        m_ptr = 0;
    endtask

    task automatic model_edge();
        if (flush_all) begin
            model_clear();
        end else if (flush_local) begin
            for (int i = 0; i < N; i++) if (!m_g[i]) m_v[i] = 0;
        end else if (flush_one) begin
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_tag[i] == flush_va[23:8] && (m_g[i] || m_asn[i] == flush_asn))
                    m_v[i] = 0;
        end else if (ins_valid) begin
            m_v[m_ptr] = 1; m_tag[m_ptr] = ins_va[23:8]; m_ppn[m_ptr] = ins_ppn;
            m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en; m_fr[m_ptr] = ins_f_rd;
            m_fw[m_ptr] = ins_f_wr; m_g[m_ptr] = ins_glob; m_asn[m_ptr] = ins_asn;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic check();
        logic [OW-1:0] exp_v, act_v;
        exp_v = '0;
        for (int i = N - 1; i >= 0; i--)
            if (m_v[i] && m_tag[i] == lk_vpn && (m_g[i] || m_asn[i] == lk_asn))
                exp_v = {1'b1, IW'(i), m_ppn[i], m_rd[i], m_wr[i], m_fr[i], m_fw[i], m_g[i]};
        act_v = {lk_hit, lk_idx, lk_ppn, lk_rd_en, lk_wr_en, lk_f_rd, lk_f_wr, lk_glob};
        n_chk++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: vpn=%h asn=%h actual=%h expected=%h",
                     req, lk_vpn, lk_asn, act_v, exp_v);
        end
    endtask

    task automatic clear_cmds();
        ins_valid = 0; flush_all = 0; flush_local = 0; flush_one = 0;
    endtask

    // one clock: compare, clock the model, drop the one-cycle commands
    task automatic tick();
        #1 check();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        clear_cmds();
    endtask

    task automatic set_ins(input logic [23:0] va, input logic [13:0] ppn,
                           input logic [3:0] rd, input logic [3:0] wr,
                           input logic fr, input logic fw, input logic g,
                           input logic [7:0] asn);
        ins_valid = 1; ins_va = va; ins_ppn = ppn; ins_rd_en = rd; ins_wr_en = wr;
        ins_f_rd = fr; ins_f_wr = fw; ins_glob = g; ins_asn = asn;
    endtask

    task automatic look(input logic [15:0] vpn, input logic [7:0] asn);
        lk_vpn = vpn; lk_asn = asn;
        tick();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        rst = 1; clear_cmds();
        lk_vpn = '0; lk_asn = '0; ins_va = '0; ins_ppn = '0; ins_rd_en = '0;
        ins_wr_en = '0; ins_f_rd = 0; ins_f_wr = 0; ins_glob = 0; ins_asn = '0;
        flush_va = '0; flush_asn = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst = 0;

        // R10: empty after reset, miss outputs zero
        req = "R10";
        look(16'h0000, 8'h00);
        look(16'h1234, 8'h05);

        // R11: insert visible right after its edge, not before
        req = "R11";
        lk_vpn = 16'h1234; lk_asn = 8'h05;
        set_ins(24'h1234_56, 14'h2AB, 4'b0011, 4'b0001, 1, 0, 0, 8'h05);
        tick();
        // R3: fields and tag (low VA bits dropped)
        req = "R3";
        look(16'h1234, 8'h05);

        // R1: address-space rule
        req = "R1";
        look(16'h1234, 8'h06);
        set_ins(24'h0777_FF, 14'h155, 4'b1111, 4'b0110, 0, 1, 1, 8'h09);
        tick();
        look(16'h0777, 8'h02);
        look(16'h0778, 8'h09);

        // R2: shared page under several spaces
        req = "R2";
        set_ins(24'h1234_00, 14'h111, 4'b0100, 4'b1000, 0, 0, 0, 8'h07);
        tick();
        look(16'h1234, 8'h07);
        look(16'h1234, 8'h05);
        set_ins(24'h1234_80, 14'h222, 4'b1010, 4'b0101, 1, 1, 1, 8'h00);
        tick();
        look(16'h1234, 8'h05);
        look(16'h1234, 8'h08);

        // R8: single-address invalidate, including global slot of that page
        req = "R8";
        flush_one = 1; flush_va = 24'h1234_AA; flush_asn = 8'h07;
        tick();
        look(16'h1234, 8'h07);
        look(16'h1234, 8'h05);
        look(16'h1234, 8'h08);
        look(16'h0777, 8'h02);

        // R7: non-global invalidate
        req = "R7";
        set_ins(24'h0050_00, 14'h050, 4'b0001, 4'b0001, 0, 0, 0, 8'h01);
        tick();
        look(16'h0050, 8'h01);
        flush_local = 1;
        tick();
        look(16'h1234, 8'h05);
        look(16'h0050, 8'h01);
        look(16'h0777, 8'h02);

        // R9: priority between commands
        req = "R9";
        flush_local = 1; flush_one = 1; flush_va = 24'h0777_00; flush_asn = 8'h00;
        tick();
        look(16'h0777, 8'h03);
        flush_one = 1; flush_va = 24'h0777_00;
        set_ins(24'h0999_00, 14'h099, 4'b0010, 4'b0010, 0, 0, 0, 8'h02);
        tick();
        look(16'h0777, 8'h03);
        look(16'h0999, 8'h02);
        set_ins(24'h0AAA_00, 14'h0AA, 4'b0010, 4'b0000, 0, 0, 0, 8'h02);
        tick();
        look(16'h0AAA, 8'h02);
        flush_all = 1;
        set_ins(24'h0BBB_00, 14'h0BB, 4'b0001, 4'b0001, 0, 0, 0, 8'h02);
        tick();
        look(16'h0BBB, 8'h02);

        // R6: everything gone and pointer back at 0
        req = "R6";
        look(16'h0AAA, 8'h02);
        set_ins(24'h0CCC_00, 14'h0CC, 4'b0001, 4'b0000, 0, 0, 0, 8'h03);
        tick();
        look(16'h0CCC, 8'h03);
        flush_all = 1;
        tick();
        look(16'h0CCC, 8'h03);

        // R4: pointer walks and wraps
        req = "R4";
        for (int k = 0; k < N + 2; k++) begin
            set_ins({16'(16'h0100 + k), 8'h00}, 14'(k), 4'(k), 4'(~k), k[0], k[1], 0, 8'h00);
            lk_vpn = 16'(16'h0100 + k); lk_asn = 8'h00;
            tick();
            look(16'(16'h0100 + k), 8'h00);
        end
        look(16'(16'h0100 + N - 1), 8'h00);

        // R5: overwritten mappings no longer hit
        req = "R5";
        look(16'h0100, 8'h00);
        look(16'h0101, 8'h00);
        look(16'h0102, 8'h00);
        look(16'(16'h0100 + N), 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule